// File: doc/BRIEF.md
# Serial OSD Register Write Port

This block is the receive-only serial front end of an on-screen display controller. A host microcontroller selects the block by pulling an active-low select line. It then clocks in one write frame, bit by bit, on a serial clock and serial data pair. All three serial pins are oversampled by the system clock through two-flop synchronizers, and edges are found after that.

A frame is 24 bits long: an 8-bit address, then a 16-bit data word, each sent least significant bit first. Only the low 14 data bits are kept. The address decides where the word goes:
- a 240-entry character memory, through a one-cycle write strobe with address and data;
- one of nine parallel control registers.

An active-low asynchronous reset clears all control registers. After reset is released, the block sweeps zeros into every character memory address. During that sweep it refuses serial writes.

Top module: `osd_serial_port`

## Requirements
- R1: A bit is taken from the data pin on each rising serial-clock edge seen while select is low. The first 8 bits form the address and the next 16 bits form the data word, each least significant bit first. Data bits 13..0 are stored; bits 15..14 are dropped.
- R2: A valid frame with address 0x00..0xEF produces exactly one single-cycle memory strobe. The strobe carries that address and data bits 13..0.
- R3: A valid frame with address 0xF0..0xF8 loads control register n = address - 0xF0 with data bits 13..0. Register n occupies ctrl_o bits [14n+13:14n]. The other registers keep their values, and no memory strobe is issued.
- R4: A valid frame with address 0xF9..0xFF changes no control register and issues no memory strobe.
- R5: A frame counts only when exactly 24 bits were received before select returns high. Shorter or longer frames are discarded without effect.
- R6: Serial-clock edges while select is high add no bits and leave no trace on the next frame.
- R7: While reset is low, all control registers read zero. After release, mem_we_o is high for 240 consecutive cycles with addresses 0..239 in order and data zero, and then falls.
- R8: A frame that completes during the clearing sweep is discarded.
- R9: Outside the sweep, each memory strobe lasts one cycle and always carries an address below 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Active-low serial select |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data |
| mem_we_o | output | 1 | Character memory write strobe |
| mem_addr_o | output | 8 | Character memory write address |
| mem_data_o | output | 14 | Character memory write data |
| ctrl_o | output | 126 | Nine 14-bit control registers, register n at bits [14n+13:14n] |

## Verification
The assertions assume the serial pins change slowly compared with the system clock. Each serial-clock level and each data setup must last at least three system clocks, so that the synchronizers see every edge once and the data bit is settled before its clock edge. The stimulus holds each serial-clock phase for four system clocks, changes data only while the serial clock is low, and leaves select high for several clocks between frames. The sweep checks assume reset is released between clock edges, which the stimulus does at a falling edge.

// File: rtl/osd_port_pkg.sv
package osd_port_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned DATA_W    = 14;
  localparam int unsigned MEM_DEPTH = 240;
  localparam int unsigned CTRL_NUM  = 9;
  localparam int unsigned CTRL_BASE = 240;
endpackage

// File: rtl/osd_pin_sync.sv
module osd_pin_sync #(
  parameter int unsigned       WIDTH = 3,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/osd_frame_rx.sv
module osd_frame_rx #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned FRAME_W = ADDR_W + WORD_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_s_i,
  input  logic              sclk_s_i,
  input  logic              sdat_s_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_q, sel_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               rise, frame_end;

  assign rise      = sclk_s_i & ~sclk_q & ~sel_s_i;
  assign frame_end = sel_s_i & ~sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
      done_o <= 1'b0;
      addr_o <= '0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      sel_q  <= sel_s_i;
      if (sel_s_i) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= {sdat_s_i, shreg[FRAME_W-1:1]};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
      done_o <= frame_end && (cnt == CNT_FULL);
      if (frame_end) begin
        addr_o <= shreg[ADDR_W-1:0];
        word_o <= shreg[FRAME_W-1:ADDR_W];
      end
    end
  end
endmodule

// File: rtl/osd_clear_sweep.sv
module osd_clear_sweep #(
  parameter int unsigned DEPTH = 240,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b1;
      addr_o <= '0;
    end else if (busy_o) begin
      if (addr_o == LAST) busy_o <= 1'b0;
      else                addr_o <= addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/osd_ctrl_bank.sv
module osd_ctrl_bank #(
  parameter int unsigned NUM = 9,
  parameter int unsigned DATA_W = 14,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [NUM*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_o[g*DATA_W +: DATA_W] <= '0;
      else if (we_i && idx_i == IDX_W'(g)) regs_o[g*DATA_W +: DATA_W] <= data_i;
    end
  end
endmodule

// File: rtl/osd_serial_port.sv
module osd_serial_port
  import osd_port_pkg::*;
#(
  parameter int unsigned P_ADDR_W    = ADDR_W,
  parameter int unsigned P_WORD_W    = WORD_W,
  parameter int unsigned P_DATA_W    = DATA_W,
  parameter int unsigned P_MEM_DEPTH = MEM_DEPTH,
  parameter int unsigned P_CTRL_NUM  = CTRL_NUM,
  parameter int unsigned P_CTRL_BASE = CTRL_BASE
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             sel_ni,
  input  logic                             sclk_i,
  input  logic                             sdat_i,
  output logic                             mem_we_o,
  output logic [P_ADDR_W-1:0]              mem_addr_o,
  output logic [P_DATA_W-1:0]              mem_data_o,
  output logic [P_CTRL_NUM*P_DATA_W-1:0]   ctrl_o
);
  localparam int unsigned IDX_W = $clog2(P_CTRL_NUM);
  localparam logic [P_ADDR_W-1:0] MEM_TOP  = P_ADDR_W'(P_MEM_DEPTH);
  localparam logic [P_ADDR_W-1:0] CTRL_LO  = P_ADDR_W'(P_CTRL_BASE);
  localparam logic [P_ADDR_W-1:0] CTRL_HI  = P_ADDR_W'(P_CTRL_BASE + P_CTRL_NUM - 1);

  logic [2:0]          pins_s;
  logic                frm_done;
  logic [P_ADDR_W-1:0] frm_addr;
  logic [P_WORD_W-1:0] frm_word;
  logic                sweep_busy;
  logic [P_ADDR_W-1:0] sweep_addr;
  logic                hit_mem, hit_ctrl;
  logic [P_ADDR_W-1:0] ctrl_off;

  osd_pin_sync #(.WIDTH(3), .RST_VAL(3'b100)) i_sync (
    .clk_i, .rst_ni,
    .d_i ({sel_ni, sclk_i, sdat_i}),
    .q_o (pins_s)
  );

  osd_frame_rx #(.ADDR_W(P_ADDR_W), .WORD_W(P_WORD_W)) i_rx (
    .clk_i, .rst_ni,
    .sel_s_i  (pins_s[2]),
    .sclk_s_i (pins_s[1]),
    .sdat_s_i (pins_s[0]),
    .done_o   (frm_done),
    .addr_o   (frm_addr),
    .word_o   (frm_word)
  );

  osd_clear_sweep #(.DEPTH(P_MEM_DEPTH), .ADDR_W(P_ADDR_W)) i_sweep (
    .clk_i, .rst_ni,
    .busy_o (sweep_busy),
    .addr_o (sweep_addr)
  );

  // frames finishing during the sweep are dropped
  assign hit_mem  = frm_done && !sweep_busy && (frm_addr < MEM_TOP);
  assign hit_ctrl = frm_done && !sweep_busy && (frm_addr >= CTRL_LO) && (frm_addr <= CTRL_HI);
  assign ctrl_off = frm_addr - CTRL_LO;

  osd_ctrl_bank #(.NUM(P_CTRL_NUM), .DATA_W(P_DATA_W)) i_ctrl (
    .clk_i, .rst_ni,
    .we_i   (hit_ctrl),
    .idx_i  (ctrl_off[IDX_W-1:0]),
    .data_i (frm_word[P_DATA_W-1:0]),
    .regs_o (ctrl_o)
  );

  assign mem_we_o   = sweep_busy | hit_mem;
  assign mem_addr_o = sweep_busy ? sweep_addr : frm_addr;
  assign mem_data_o = sweep_busy ? '0 : frm_word[P_DATA_W-1:0];
endmodule

// File: rtl/osd_serial_port_chk.sv
module osd_serial_port_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 14,
  parameter int unsigned CW = 126,
  parameter int unsigned DEPTH = 240
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sweeping_i,
  input logic          done_i,
  input logic          mem_we_i,
  input logic [AW-1:0] mem_addr_i,
  input logic [DW-1:0] mem_data_i,
  input logic [CW-1:0] ctrl_i
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH);

  assert_sweep_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweeping_i |-> (mem_we_i && mem_data_i == '0));

  assert_sweep_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweeping_i |=> (!sweeping_i || mem_addr_i == $past(mem_addr_i) + 1'b1));

  assert_single_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && !sweeping_i) |=> !mem_we_i);

  assert_addr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && !sweeping_i) |-> (mem_addr_i < TOP));

  assert_ctrl_only_on_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(ctrl_i));

  assert_strobe_needs_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && !sweeping_i) |-> done_i);
endmodule

bind osd_serial_port osd_serial_port_chk #(
  .AW(P_ADDR_W), .DW(P_DATA_W), .CW(P_CTRL_NUM*P_DATA_W), .DEPTH(P_MEM_DEPTH)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sweeping_i (sweep_busy),
  .done_i     (frm_done),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .mem_data_i (mem_data_o),
  .ctrl_i     (ctrl_o)
);

// File: tb/test_osd_serial_port.sv
module test_osd_serial_port;
  localparam int NREG = 9;
  localparam int NVEC = 12;
  // {nbits[4:0], addr[7:0], data[15:0]}
  localparam logic [28:0] VEC [NVEC] = '{
    {5'd24, 8'h00, 16'h3FFF}, {5'd24, 8'hEF, 16'hC123},
    {5'd24, 8'hF0, 16'h2AAA}, {5'd24, 8'hF8, 16'h1555},
    {5'd24, 8'hF4, 16'hFFFF}, {5'd24, 8'hF9, 16'h1111},
    {5'd24, 8'hFF, 16'h2222}, {5'd23, 8'h05, 16'h0777},
    {5'd25, 8'hF1, 16'h0333}, {5'd8,  8'hF1, 16'h0333},
    {5'd24, 8'h7A, 16'h1ABC}, {5'd24, 8'hF1, 16'h0001}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, sel_ni = 1'b1, sclk_i = 1'b0, sdat_i = 1'b0;
  logic        mem_we_o;
  logic [7:0]  mem_addr_o;
  logic [13:0] mem_data_o;
  logic [125:0] ctrl_o;

  int checks = 0, errors = 0;
  int n_strobe = 0;
  logic [7:0]  last_addr;
  logic [13:0] last_data;
  logic [125:0] model;

  osd_serial_port i_osd_serial_port (.*);

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (rst_ni && mem_we_o) begin
      n_strobe  <= n_strobe + 1;
      last_addr <= mem_addr_o;
      last_data <= mem_data_o;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] a, input logic [15:0] d, input int nbits);
    sel_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < nbits; i++) begin
      sdat_i = (i < 8) ? a[i] : (i < 24) ? d[i-8] : 1'b0;
      repeat (4) @(negedge clk_i);
      sclk_i = 1'b1;
      repeat (4) @(negedge clk_i);
      sclk_i = 1'b0;
    end
    repeat (4) @(negedge clk_i);
    sel_ni = 1'b1;
    repeat (12) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(ctrl_o == '0, "R7 ctrl zero in reset", 128'(ctrl_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    bit sweep_ok;
    model = '0;
    @(negedge clk_i);
    do_reset();
    // R7 sweep walk
    #1;
    sweep_ok = 1'b1;
    for (int i = 0; i < 240; i++) begin
      if (!(mem_we_o && mem_addr_o == 8'(i) && mem_data_o == '0)) sweep_ok = 1'b0;
      @(negedge clk_i);
    end
    check(sweep_ok, "R7 sweep addresses", 128'(sweep_ok), 1);
    check(!mem_we_o, "R7 strobe falls after sweep", 128'(mem_we_o), 0);
    repeat (4) @(negedge clk_i);

    // vector table: R1 R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0]  nb;
      logic [7:0]  a;
      logic [15:0] d;
      int exp_cnt;
      {nb, a, d} = VEC[v];
      base = n_strobe;
      exp_cnt = 0;
      if (nb == 5'd24) begin
        if (a < 8'hF0) exp_cnt = 1;
        else if (a <= 8'hF8) model[(a - 8'hF0)*14 +: 14] = d[13:0];
      end
      send(a, d, int'(nb));
      check(n_strobe - base == exp_cnt, "R2 R4 R5 strobe count", 128'(n_strobe - base), 128'(exp_cnt));
      if (exp_cnt == 1)
        check(last_addr == a && last_data == d[13:0], "R1 R2 memory write",
              {last_addr, last_data}, {a, d[13:0]});
      check(ctrl_o == model, "R1 R3 R4 R5 control registers", 128'(ctrl_o), 128'(model));
    end

    // R6: clock edges while deselected
    for (int i = 0; i < 5; i++) begin
      sdat_i = 1'b1;
      repeat (4) @(negedge clk_i);
      sclk_i = 1'b1;
      repeat (4) @(negedge clk_i);
      sclk_i = 1'b0;
    end
    repeat (6) @(negedge clk_i);
    check(ctrl_o == model, "R6 no effect while deselected", 128'(ctrl_o), 128'(model));
    send(8'hF2, 16'h0A5C, 24);
    model[2*14 +: 14] = 14'h0A5C;
    check(ctrl_o == model, "R6 next frame clean", 128'(ctrl_o), 128'(model));

    // R9 back-to-back memory writes
    base = n_strobe;
    send(8'h10, 16'h0101, 24);
    send(8'h11, 16'h0202, 24);
    check(n_strobe - base == 2 && last_addr == 8'h11 && last_data == 14'h0202,
          "R9 one strobe per frame", 128'(n_strobe - base), 2);

    // R8: frame completing during sweep
    @(negedge clk_i);
    do_reset();
    model = '0;
    base = n_strobe;
    send(8'hF0, 16'h1234, 24);
    send(8'h03, 16'h0055, 0);
    repeat (60) @(negedge clk_i);
    check(ctrl_o == '0, "R8 ctrl frame dropped in sweep", 128'(ctrl_o), 0);
    check(n_strobe - base == 240, "R8 only sweep strobes", 128'(n_strobe - base), 240);
    send(8'hF3, 16'h0042, 24);
    model[3*14 +: 14] = 14'h0042;
    check(ctrl_o == model, "R3 write after sweep", 128'(ctrl_o), 128'(model));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule